// File: doc/BRIEF.md
# Parallel ADC Sampler with Single-Precision Output

This block runs the conversion handshake of an external 8-bit parallel analog-to-digital converter. It takes in each finished sample and undoes a fixed ×4 attenuation in the analog front end. It then delivers the rescaled value as an IEEE-754 single-precision word to a floating-point datapath further down the chain. A controller asks for a sample by pulsing `start_i`. The block pulls both converter strobes low and waits for the converter to pull its active-low ready line down. It latches the data bus, releases the strobes and, one cycle later, presents the encoded value with a one-cycle valid pulse.

The gain correction is a two-bit left shift on the integer code. The result, `code × 4`, lies in 0..1020, so every one of the 256 codes has an exact float encoding. A priority encoder finds the leading one of the shifted value. The exponent is 127 plus that bit's position, and the bits below it are left-aligned into the 23-bit fraction. If the converter never signals ready, a cycle budget ends the wait, raises a one-cycle timeout pulse and returns to idle. A conversion takes about 2 µs, which is 100 cycles at 50 MHz, so the default budget of 200 cycles leaves a twofold margin.

Top module: `adc_float_capture`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises: `conv_n_o` and `rd_n_o` are 1, `valid_o` and `timeout_o` are 0, and `value_o` is 32'h0.
- R2: A `start_i` sampled high at a clock edge while idle drives both `conv_n_o` and `rd_n_o` to 0 in the following cycle. The two strobes always carry the same value.
- R3: At the first edge during the wait at which `adc_rdy_n_i` is 0, `adc_data_i` is latched. Both strobes are 1 from the next cycle on, and later changes of `adc_data_i` do not alter the delivered result.
- R4: `valid_o` is 1 for exactly one cycle, the cycle after the strobes are released. `value_o` keeps the delivered word until the next delivery.
- R5: For a nonzero code c, `value_o` equals the IEEE-754 single-precision encoding of the integer 4·c, and the result is exact. Bit 31 (sign) is 0. Bits 30:23 hold 127 plus the position of the leading one of 4·c. Bits 22:0 hold the bits below that leading one, left-aligned with zero fill.
- R6: Code 0 is delivered as 32'h0000_0000 (+0.0).
- R7: If `adc_rdy_n_i` stays 1 at 200 consecutive edges of the wait, `timeout_o` pulses for exactly one cycle right after the 200th. In that cycle both strobes are 1 again, and no `valid_o` is produced for the attempt.
- R8: A ready seen at the 200th edge of the wait is still captured normally, and no timeout is raised.
- R9: `start_i` has no effect while a request is in progress. `adc_rdy_n_i` has no effect while idle: it yields neither `valid_o` nor a change of `value_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request one conversion |
| adc_data_i | input | 8 | Converter data bus, unsigned code |
| adc_rdy_n_i | input | 1 | Converter ready, active low |
| conv_n_o | output | 1 | Conversion strobe, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| value_o | output | 32 | Rescaled sample, IEEE-754 single precision |
| valid_o | output | 1 | One-cycle pulse marking a new `value_o` |
| timeout_o | output | 1 | One-cycle pulse when the ready wait is abandoned |

## Verification
The assertions assume that the converter lowers ready only in answer to a request. They also assume that start pulses arrive only while the block is idle, apart from deliberate busy-time retriggers. The bench models a converter that answers strictly after the strobes fall and lifts ready again in the cycle after capture. It drives a different byte onto the data bus at that moment, so a late sample would show up. Every code is swept with varying ready latencies, and the 199/200-edge timeout boundary is hit from both sides.

// File: rtl/adc_cap_pkg.sv
// Package: shared sizes and the sequencer state type for the ADC sampler.
// Assumes: an 8-bit converter and a fixed power-of-two front-end gain.
package adc_cap_pkg;
    localparam int CODE_W      = 8;    // converter resolution
    localparam int GAIN_SHIFT  = 2;    // x4 attenuation compensation
    localparam int TIMEOUT_CYC = 200;  // ready wait budget in cycles
    localparam int EXP_W       = 8;
    localparam int FRAC_W      = 23;
    localparam int EXP_BIAS    = 127;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_PACK = 2'd2
    } seq_state_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
// Module: converter handshake sequencer.
// Does: starts a conversion, waits for active-low ready within a budget,
//       latches the data bus, and flags either a pack step or a timeout.
// Assumes: ready is sampled synchronously; start is a level sampled when idle.
module adc_seq_ctrl
    import adc_cap_pkg::*;
#(
    parameter int DATA_W  = CODE_W,
    parameter int WAIT_MAX = TIMEOUT_CYC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              rdy_n_i,
    output logic              strobe_n_o,
    output logic [DATA_W-1:0] code_o,
    output logic              pack_o,
    output logic              abort_o
);
    localparam int CNT_W = (WAIT_MAX > 1) ? $clog2(WAIT_MAX) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_MAX - 1);

    seq_state_t        state_q;
    logic [CNT_W-1:0]  wait_cnt_q;
    logic [DATA_W-1:0] code_q;
    logic              abort_q;

    // State, wait counter, sample latch and abort pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SEQ_IDLE;
            wait_cnt_q <= '0;
            code_q     <= '0;
            abort_q    <= 1'b0;
        end else begin
            abort_q <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    wait_cnt_q <= '0;
                    if (start_i) state_q <= SEQ_WAIT;
                end
                SEQ_WAIT: begin
                    if (!rdy_n_i) begin
                        code_q  <= data_i;
                        state_q <= SEQ_PACK;
                    end else if (wait_cnt_q == CNT_LAST) begin
                        abort_q <= 1'b1;
                        state_q <= SEQ_IDLE;
                    end else begin
                        wait_cnt_q <= wait_cnt_q + 1'b1;
                    end
                end
                SEQ_PACK: state_q <= SEQ_IDLE;
                default:  state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Strobes low only while waiting for the converter.
    assign strobe_n_o = (state_q != SEQ_WAIT);
    assign code_o     = code_q;
    assign pack_o     = (state_q == SEQ_PACK);
    assign abort_o    = abort_q;
endmodule

// File: rtl/gain_shift.sv
// Module: fixed power-of-two gain compensation.
// Does: multiplies the unsigned code by 2**SHIFT with no rounding.
// Assumes: the output is wide enough for the full product.
module gain_shift #(
    parameter int IN_W  = 8,
    parameter int SHIFT = 2
) (
    input  logic [IN_W-1:0]       code_i,
    output logic [IN_W+SHIFT-1:0] scaled_o
);
    // Append SHIFT zero bits below the code.
    generate
        if (SHIFT > 0) begin : g_shift
            assign scaled_o = {code_i, {SHIFT{1'b0}}};
        end else begin : g_pass
            assign scaled_o = code_i;
        end
    endgenerate
endmodule

// File: rtl/float_packer.sv
// Module: unsigned integer to IEEE-754 single-precision encoder.
// Does: finds the leading one, forms the biased exponent and left-aligns the
//       bits below it into the fraction; zero maps to +0.0.
// Assumes: input is non-negative; exact whenever IN_W <= FRAC_W + 1.
module float_packer
    import adc_cap_pkg::*;
#(
    parameter int IN_W = 10
) (
    input  logic [IN_W-1:0] val_i,
    output logic [31:0]     float_o
);
    localparam int LEAD_W = (IN_W > 1) ? $clog2(IN_W) : 1;

    logic [LEAD_W-1:0] lead;
    logic [IN_W-1:0]   below;
    logic [FRAC_W-1:0] frac;
    logic [EXP_W-1:0]  expo;

    // Priority encoder: the highest set bit wins.
    always_comb begin
        lead = '0;
        for (int i = 0; i < IN_W; i++) begin
            if (val_i[i]) lead = LEAD_W'(i);
        end
    end

    // Shift the leading one out of the top, leaving the lower bits aligned.
    always_comb begin
        below = val_i << (IN_W - int'(lead));
    end

    // Pad or truncate the aligned bits into the fraction field.
    generate
        if (IN_W <= FRAC_W) begin : g_pad
            assign frac = {below, {(FRAC_W - IN_W){1'b0}}};
        end else begin : g_trunc
            assign frac = below[IN_W-1 -: FRAC_W];
        end
    endgenerate

    assign expo = EXP_W'(EXP_BIAS) + EXP_W'(lead);

    // Assemble the word; zero is special-cased to all zeros.
    always_comb begin
        if (val_i == '0) float_o = 32'h0;
        else             float_o = {1'b0, expo, frac};
    end
endmodule

// File: rtl/adc_float_capture.sv
// Module: top of the ADC sampler with single-precision output.
// Does: converter handshake, x4 rescale, float encoding, registered delivery.
// Assumes: one converter, one outstanding request at a time.
module adc_float_capture
    import adc_cap_pkg::*;
#(
    parameter int DATA_W   = CODE_W,
    parameter int SHIFT    = GAIN_SHIFT,
    parameter int WAIT_MAX = TIMEOUT_CYC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] adc_data_i,
    input  logic              adc_rdy_n_i,
    output logic              conv_n_o,
    output logic              rd_n_o,
    output logic [31:0]       value_o,
    output logic              valid_o,
    output logic              timeout_o
);
    localparam int VAL_W = DATA_W + SHIFT;

    logic              strobe_n;
    logic [DATA_W-1:0] code;
    logic              pack_go;
    logic              abort;
    logic [VAL_W-1:0]  scaled;
    logic [31:0]       packed_w;
    logic [31:0]       value_q;
    logic              valid_q;

    adc_seq_ctrl #(.DATA_W(DATA_W), .WAIT_MAX(WAIT_MAX)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(adc_data_i),
        .rdy_n_i(adc_rdy_n_i), .strobe_n_o(strobe_n), .code_o(code),
        .pack_o(pack_go), .abort_o(abort)
    );

    gain_shift #(.IN_W(DATA_W), .SHIFT(SHIFT)) u_gain (
        .code_i(code), .scaled_o(scaled)
    );

    float_packer #(.IN_W(VAL_W)) u_pack (
        .val_i(scaled), .float_o(packed_w)
    );

    // Output register: load the encoded word on the pack step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= pack_go;
            if (pack_go) value_q <= packed_w;
        end
    end

    assign conv_n_o  = strobe_n;
    assign rd_n_o    = strobe_n;
    assign value_o   = value_q;
    assign valid_o   = valid_q;
    assign timeout_o = abort;
endmodule

// File: rtl/adc_float_capture_chk.sv
// Module: property checker for the ADC sampler, bound to the top.
// Does: checks port-level pulse shapes and encoding invariants.
// Assumes: synchronous active-low reset.
module adc_float_capture_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        conv_n_o,
    input logic        rd_n_o,
    input logic [31:0] value_o,
    input logic        valid_o,
    input logic        timeout_o
);
    a_r2_strobes_match: assert property (@(posedge clk) disable iff (!rst_n)
        conv_n_o == rd_n_o);

    a_r3_released_at_valid: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (conv_n_o && rd_n_o));

    a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    a_r4_value_held: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |=> (!valid_o || 1'b1) && ($stable(value_o) || valid_o));

    a_r5_sign_clear: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !value_o[31]);

    a_r6_zero_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && value_o[30:23] == 8'd0) |-> (value_o == 32'h0));

    a_r7_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o);

    a_r7_timeout_released: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (conv_n_o && !valid_o));
endmodule

bind adc_float_capture adc_float_capture_chk u_chk (
    .clk(clk), .rst_n(rst_n), .conv_n_o(conv_n_o), .rd_n_o(rd_n_o),
    .value_o(value_o), .valid_o(valid_o), .timeout_o(timeout_o)
);

// File: tb/tb_adc_float_capture.sv
// Bench: sweeps every code with varying ready latency, then the timeout
// boundary and the ignored-input cases. Reference floats come from $realtobits.
module tb_adc_float_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  adc_data_i = 8'h00;
    logic        adc_rdy_n_i = 1'b1;
    logic        conv_n_o, rd_n_o, valid_o, timeout_o;
    logic [31:0] value_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    adc_float_capture dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .adc_data_i(adc_data_i),
        .adc_rdy_n_i(adc_rdy_n_i), .conv_n_o(conv_n_o), .rd_n_o(rd_n_o),
        .value_o(value_o), .valid_o(valid_o), .timeout_o(timeout_o)
    );

    // Reference: exact single-precision bits of 4*code via double conversion.
    function automatic logic [31:0] ref_float(int code);
        logic [63:0] d;
        int          e;
        if (code == 0) return 32'h0;
        d = $realtobits(real'(code) * 4.0);
        e = int'(d[62:52]) - 1023 + 127;
        return {1'b0, e[7:0], d[51:29]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One conversion: ready appears lat cycles after the strobes fall.
    task automatic convert(int code, int lat);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        check("R2 strobes low", {30'd0, conv_n_o, rd_n_o}, 32'd0);
        repeat (lat) @(negedge clk);
        adc_rdy_n_i = 1'b0;
        adc_data_i  = 8'(code);
        @(negedge clk);
        adc_rdy_n_i = 1'b1;
        adc_data_i  = 8'(code) ^ 8'hA5;
        check("R3 strobes released", {30'd0, conv_n_o, rd_n_o}, 32'd3);
        check("R4 no early valid", {31'd0, valid_o}, 32'd0);
        @(negedge clk);
        check("R4 valid pulse", {31'd0, valid_o}, 32'd1);
        check(code == 0 ? "R6 zero code" : "R5 float value", value_o, ref_float(code));
        @(negedge clk);
        check("R4 valid single", {31'd0, valid_o}, 32'd0);
        check("R4 value held", value_o, ref_float(code));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset strobes", {30'd0, conv_n_o, rd_n_o}, 32'd3);
        check("R1 reset flags", {30'd0, valid_o, timeout_o}, 32'd0);
        check("R1 reset value", value_o, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {28'd0, conv_n_o, rd_n_o, valid_o, timeout_o}, 32'hC);

        // R5/R6: every code, latency cycling 0..6.
        for (int c = 0; c < 256; c++) convert(c, c % 7);

        // R8: ready on the 200th wait edge is captured.
        convert(8'hC3, 199);
        check("R8 no timeout", {31'd0, timeout_o}, 32'd0);

        // R7: ready never arrives.
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (199) @(negedge clk);
        check("R7 not yet", {31'd0, timeout_o}, 32'd0);
        @(negedge clk);
        check("R7 timeout pulse", {31'd0, timeout_o}, 32'd1);
        check("R7 strobes released", {30'd0, conv_n_o, rd_n_o}, 32'd3);
        check("R7 no valid", {31'd0, valid_o}, 32'd0);
        @(negedge clk);
        check("R7 timeout single", {31'd0, timeout_o}, 32'd0);
        check("R7 value kept", value_o, ref_float(8'hC3));

        // R9: ready while idle has no effect.
        adc_rdy_n_i = 1'b0;
        adc_data_i  = 8'h11;
        repeat (3) @(negedge clk);
        check("R9 idle ready no valid", {31'd0, valid_o}, 32'd0);
        check("R9 idle ready value", value_o, ref_float(8'hC3));
        check("R9 idle strobes", {30'd0, conv_n_o, rd_n_o}, 32'd3);
        adc_rdy_n_i = 1'b1;

        // R9: start while busy is ignored; block idles after one delivery.
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        adc_rdy_n_i = 1'b0;
        adc_data_i  = 8'h40;
        @(negedge clk) adc_rdy_n_i = 1'b1;
        @(negedge clk);
        check("R9 busy start value", value_o, ref_float(8'h40));
        @(negedge clk);
        check("R9 busy start idle", {30'd0, conv_n_o, rd_n_o}, 32'd3);
        repeat (3) @(negedge clk);
        check("R9 no second valid", {31'd0, valid_o}, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule